// File: doc/BRIEF.md
# Watchdog Timer with Delayed System Reset

This block watches for software that has stopped servicing it. Its clock is a slow dedicated watchdog clock. An 18-bit up counter runs while the watchdog is on. When the counter has run through a selectable power-of-two number of clocks, the block records a time-out. The time-out sets a sticky interrupt flag and, if the conditions for it are met, a sticky wake-up flag.

The time-out does not reset the system at once. It starts a grace period of 3, 18, 130 or 1026 clocks, chosen by software. If software restarts the counter before the grace period ends, nothing more happens. If it does not, and resets are permitted, the block drives a system reset pulse of fixed length and records that it did so. A configuration input can hold the watchdog on whatever software writes to the enable bit.

All software access goes through a single 13-bit control word. Writing it updates the enables and the selects in the same cycle. Writing 1 to the counter-clear bit restarts the count. Writing 1 to a flag bit clears that flag. The outputs are plain level signals with no handshake.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` is released, `ctl_rdata` reads 0 and `irq_o`, `wake_o` and `wdt_rst_o` are all 0.
- R2: The interval select sits in control bits 10:8. Code k gives an interval of 2^(4+2k) clocks, so codes 0 to 7 give 2^4 up to 2^18. With the watchdog running, the interrupt flag (bit 3) reads 1 exactly that many clocks after the write edge that cleared the counter.
- R3: The interrupt flag (bit 3) is sticky and clears when 1 is written to it. `irq_o` is 1 only while both the flag and the interrupt enable (bit 6) are 1.
- R4: A time-out sets the wake flag (bit 5) only when the wake enable (bit 4) is 1 and `slow_clk_sel` is 1 in that cycle. `wake_o` follows the wake flag. The wake flag clears when 1 is written to it.
- R5: The delay select sits in control bits 12:11. Codes 0, 1, 2 and 3 select 1026, 130, 18 and 3 clocks. `wdt_rst_o` rises exactly that many clocks after the interrupt flag rises.
- R6: Once `wdt_rst_o` rises, it stays 1 for exactly 63 clocks.
- R7: A reset pulse starts only when the reset enable (bit 1) is 1. The reset flag (bit 2) is set in the cycle the pulse starts. It is sticky and clears when 1 is written to it.
- R8: Writing 1 to the counter-clear bit (bit 0) does three things. It restarts the count from zero, it cancels a pending reset that has not yet started, and it reads back as 1 for one clock only.
- R9: Turning the watchdog off cancels a pending reset and zeroes the counter. After it is turned on again, the next time-out comes one full interval after the enable edge.
- R10: While `force_en` is 1, the watchdog counts even if the enable bit (bit 7) is 0, and bit 7 reads as 1.
- R11: While the watchdog is off, no time-out occurs and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 13 | Control word write data |
| ctl_rdata | output | 13 | Control word read-back (bit 7 shows the effective enable) |
| force_en | input | 1 | Configuration force-enable |
| slow_clk_sel | input | 1 | Qualifier: the slow oscillator is the clock source (needed for wake-up) |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
The bench measures, to the exact clock, the gap from a counter clear to the interrupt flag for three interval codes. It measures the gap from the flag to the reset for all four delay codes, and the width of the reset pulse. An off-by-one in the masked compare or in the down counter shows up as a count of 15 or 17 instead of 16, or as a pulse of 62 or 64 clocks.

The bench clears the counter in the middle of a grace period and checks two things. The old reset must not fire about 13 clocks later. The new reset must land at 34 clocks, which is a fresh interval plus the grace period. A design that ignored the cancel would reset early. A design that also blocked new time-outs would never reset.

The bench turns the watchdog off during a grace period and checks that no reset appears and that the count restarts from zero. It also checks the wake flag with the slow-clock qualifier low, a reset enable of 0, and the force-enable path.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Control word bit positions
  localparam int B_CLR      = 0;
  localparam int B_RST_ARM  = 1;
  localparam int B_RST_HIT  = 2;
  localparam int B_IRQ_HIT  = 3;
  localparam int B_WAKE_ARM = 4;
  localparam int B_WAKE_HIT = 5;
  localparam int B_IRQ_ARM  = 6;
  localparam int B_RUN      = 7;
  localparam int ISEL_W     = 3;
  localparam int B_ISEL_LO  = 8;
  localparam int DSEL_W     = 2;
  localparam int B_DSEL_LO  = B_ISEL_LO + ISEL_W;
  localparam int CTL_W      = B_DSEL_LO + DSEL_W;

  typedef struct packed {
    logic              run;
    logic              irq_arm;
    logic              wake_arm;
    logic              rst_arm;
    logic [ISEL_W-1:0] isel;
    logic [DSEL_W-1:0] dsel;
  } wdog_cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_GRACE = 2'd1,
    SEQ_PULSE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wdog_ctl_regs.sv
module wdog_ctl_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             force_en,
  input  logic             irq_set,
  input  logic             wake_set,
  input  logic             rst_set,
  output wdog_cfg_t        cfg,
  output logic             run,
  output logic             clr_req,
  output logic             irq_flag,
  output logic             wake_flag,
  output logic             rst_flag,
  output logic [CTL_W-1:0] rdata
);
  localparam int NFLAG = 3;
  localparam int FLAG_POS [NFLAG] = '{B_IRQ_HIT, B_WAKE_HIT, B_RST_HIT};

  wdog_cfg_t        cfg_q;
  logic             clr_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;

  assign flag_set = {rst_set, wake_set, irq_set};
  assign clr_req  = wr & wdata[B_CLR];

  // Sticky flags: a hardware set wins over a software clear in the same cycle
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q <= 1'b0;
      else if (flag_set[g])          q <= 1'b1;
      else if (wr && wdata[FLAG_POS[g]]) q <= 1'b0;
    end
    assign flag_q[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_req;
      if (wr) begin
        cfg_q.run      <= wdata[B_RUN];
        cfg_q.irq_arm  <= wdata[B_IRQ_ARM];
        cfg_q.wake_arm <= wdata[B_WAKE_ARM];
        cfg_q.rst_arm  <= wdata[B_RST_ARM];
        cfg_q.isel     <= wdata[B_ISEL_LO +: ISEL_W];
        cfg_q.dsel     <= wdata[B_DSEL_LO +: DSEL_W];
      end
    end
  end

  assign cfg       = cfg_q;
  assign run       = cfg_q.run | force_en;
  assign irq_flag  = flag_q[0];
  assign wake_flag = flag_q[1];
  assign rst_flag  = flag_q[2];

  always_comb begin
    rdata                          = '0;
    rdata[B_CLR]                   = clr_q;
    rdata[B_RST_ARM]               = cfg_q.rst_arm;
    rdata[B_RST_HIT]               = rst_flag;
    rdata[B_IRQ_HIT]               = irq_flag;
    rdata[B_WAKE_ARM]              = cfg_q.wake_arm;
    rdata[B_WAKE_HIT]              = wake_flag;
    rdata[B_IRQ_ARM]               = cfg_q.irq_arm;
    rdata[B_RUN]                   = run;
    rdata[B_ISEL_LO +: ISEL_W]     = cfg_q.isel;
    rdata[B_DSEL_LO +: DSEL_W]     = cfg_q.dsel;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W    = 18,
  parameter int SEL_W    = 3,
  parameter int LOG_MIN  = 4,
  parameter int LOG_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] isel,
  output logic             tout
);
  localparam int MASK_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // Low-order ones mask of width LOG_MIN + LOG_STEP*isel
  function automatic logic [CNT_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
    logic [MASK_W-1:0] m;
    m = (MASK_W'(1) << (LOG_MIN + LOG_STEP * int'(s))) - MASK_W'(1);
    return m[CNT_W-1:0];
  endfunction

  assign mask = sel_mask(isel);
  assign tout = run & ~clr & ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run || clr) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_rst_seq.sv
module wdog_rst_seq
  import wdog_pkg::*;
#(
  parameter int unsigned RST_LEN = 63,
  parameter int unsigned DLY_TAB [4] = '{1026, 130, 18, 3}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              tout,
  input  logic              rst_arm,
  input  logic [DSEL_W-1:0] dsel,
  output logic              rst_start,
  output logic              rst_o
);
  function automatic int unsigned span_max();
    int unsigned m = RST_LEN;
    for (int i = 0; i < 4; i++) if (DLY_TAB[i] > m) m = DLY_TAB[i];
    return m;
  endfunction

  localparam int CW = $clog2(span_max() + 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign rst_start = (st_q == SEQ_GRACE) && run && !clr && cnt_zero && rst_arm;
  assign rst_o     = (st_q == SEQ_PULSE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (tout) begin
          st_d  = SEQ_GRACE;
          cnt_d = CW'(DLY_TAB[dsel] - 1);
        end
      end
      SEQ_GRACE: begin
        if (!run || clr) begin
          st_d  = SEQ_IDLE;
          cnt_d = '0;
        end else if (cnt_zero) begin
          if (rst_arm) begin
            st_d  = SEQ_PULSE;
            cnt_d = CW'(RST_LEN - 1);
          end else begin
            st_d = SEQ_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SEQ_PULSE: begin
        if (cnt_zero) st_d = SEQ_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: begin
        st_d  = SEQ_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 18,
  parameter int          LOG_MIN  = 4,
  parameter int          LOG_STEP = 2,
  parameter int unsigned RST_LEN  = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             force_en,
  input  logic             slow_clk_sel,
  output logic             irq_o,
  output logic             wake_o,
  output logic             wdt_rst_o
);
  wdog_cfg_t cfg;
  logic run, clr_req, tout, rst_start;
  logic irq_flag, wake_flag, rst_flag;

  wdog_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctl_wr),
    .wdata     (ctl_wdata),
    .force_en  (force_en),
    .irq_set   (tout),
    .wake_set  (tout & cfg.wake_arm & slow_clk_sel),
    .rst_set   (rst_start),
    .cfg       (cfg),
    .run       (run),
    .clr_req   (clr_req),
    .irq_flag  (irq_flag),
    .wake_flag (wake_flag),
    .rst_flag  (rst_flag),
    .rdata     (ctl_rdata)
  );

  wdog_counter #(
    .CNT_W    (CNT_W),
    .SEL_W    (ISEL_W),
    .LOG_MIN  (LOG_MIN),
    .LOG_STEP (LOG_STEP)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (clr_req | rst_start),
    .isel  (cfg.isel),
    .tout  (tout)
  );

  wdog_rst_seq #(
    .RST_LEN (RST_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (clr_req),
    .tout      (tout),
    .rst_arm   (cfg.rst_arm),
    .dsel      (cfg.dsel),
    .rst_start (rst_start),
    .rst_o     (wdt_rst_o)
  );

  assign irq_o  = irq_flag & cfg.irq_arm;
  assign wake_o = wake_flag;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned RST_LEN = 63,
  parameter int          CTL_W   = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_wr,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             force_en,
  input logic             slow_clk_sel,
  input logic             irq_o,
  input logic             wake_o,
  input logic             wdt_rst_o
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= '0;
    else if (wdt_rst_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctl_rdata[6] && ctl_rdata[3])); // R3
  AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> ($past(slow_clk_sel) && $past(ctl_rdata[4]))); // R4
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_o) |-> (hi_run == 16'(RST_LEN))); // R6
  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> (hi_run < 16'(RST_LEN))); // R6
  AST_RESET_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(ctl_rdata[1])); // R7
  AST_RESET_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> ctl_rdata[2]); // R7
  AST_CLEAR_SELF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[0] && !clr_wr) |=> !ctl_rdata[0]); // R8
  AST_RESET_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(ctl_rdata[7])); // R9
  AST_FORCE_SHOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |-> ctl_rdata[7]); // R10
endmodule

bind wdog_top wdog_chk #(.RST_LEN(RST_LEN), .CTL_W(wdog_pkg::CTL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_wr       (ctl_wr & ctl_wdata[0]),
  .ctl_rdata    (ctl_rdata),
  .force_en     (force_en),
  .slow_clk_sel (slow_clk_sel),
  .irq_o        (irq_o),
  .wake_o       (wake_o),
  .wdt_rst_o    (wdt_rst_o)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;
  localparam int W = 13;
  localparam logic [W-1:0] M_CLR = 13'h001, M_RSTF = 13'h004,
                           M_INTF = 13'h008, M_WKF = 13'h020;

  logic clk = 1'b0, rst_n = 1'b0, ctl_wr = 1'b0, force_en = 1'b0, slow_clk_sel = 1'b0;
  logic [W-1:0] ctl_wdata = '0;
  logic [W-1:0] ctl_rdata;
  logic irq_o, wake_o, wdt_rst_o;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_top i_wdog_top (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .force_en(force_en), .slow_clk_sel(slow_clk_sel),
    .irq_o(irq_o), .wake_o(wake_o), .wdt_rst_o(wdt_rst_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [W-1:0] cw(input bit en, ie, we, re,
                                      input int isel, input int dsel);
    logic [W-1:0] v = '0;
    v[7] = en; v[6] = ie; v[4] = we; v[1] = re;
    v[10:8] = 3'(isel); v[12:11] = 2'(dsel);
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; ctl_wr = 0; ctl_wdata = '0; force_en = 0; slow_clk_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [W-1:0] v);
    ctl_wdata = v; ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0; ctl_wdata = '0;
  endtask

  // Edges until control bit b reads 1; -1 when not within lim
  task automatic wait_bit(input int b, input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (ctl_rdata[b]) begin n = i; break; end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rdata", int'(ctl_rdata), 0);
    chk("R1 outputs", int'({irq_o, wake_o, wdt_rst_o}), 0);
    repeat (300) @(negedge clk);
    chk("R11 no flag while off", int'(ctl_rdata[3] | ctl_rdata[5] | ctl_rdata[2]), 0);
  endtask

  task automatic t_interval(input int code);
    int n;
    do_reset();
    wr(cw(1, 0, 0, 0, code, 0) | M_CLR);
    wait_bit(3, 300, n);
    chk($sformatf("R2 interval code %0d", code), n, 1 << (4 + 2 * code));
    if (code == 0) begin
      chk("R3 irq masked", int'(irq_o), 0);
      wr(cw(1, 1, 0, 0, 0, 0));
      chk("R3 irq unmasked", int'(irq_o), 1);
      wr(cw(1, 1, 0, 0, 0, 0) | M_INTF);
      chk("R3 flag cleared", int'(ctl_rdata[3]), 0);
      chk("R3 irq dropped", int'(irq_o), 0);
    end
  endtask

  task automatic t_wake();
    int n;
    do_reset();
    wr(cw(1, 0, 1, 0, 0, 0) | M_CLR);
    wait_bit(3, 40, n);
    chk("R4 qualifier low flag", int'(ctl_rdata[5]), 0);
    chk("R4 qualifier low out", int'(wake_o), 0);
    slow_clk_sel = 1;
    wait_bit(5, 40, n);
    chk("R4 wake flag seen", int'(n > 0), 1);
    chk("R4 wake out", int'(wake_o), 1);
    wr(cw(1, 0, 1, 0, 0, 0) | M_WKF);
    chk("R4 wake cleared", int'(wake_o), 0);
  endtask

  task automatic t_delay(input int code, input int exp_d);
    int n, d, h;
    do_reset();
    wr(cw(1, 0, 0, 1, 0, code) | M_CLR);
    wait_bit(3, 40, n);
    d = -1;
    for (int i = 1; i <= 1100; i++) begin
      @(negedge clk);
      if (wdt_rst_o) begin d = i; break; end
    end
    chk($sformatf("R5 delay code %0d", code), d, exp_d);
    chk("R7 reset flag at start", int'(ctl_rdata[2]), 1);
    h = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wdt_rst_o) h++; else break;
    end
    chk("R6 pulse width", h, 63);
    wr(cw(1, 0, 0, 1, 0, code) | M_RSTF);
    chk("R7 reset flag cleared", int'(ctl_rdata[2]), 0);
  endtask

  task automatic t_no_arm();
    int n, seen = 0;
    do_reset();
    wr(cw(1, 0, 0, 0, 0, 3) | M_CLR);
    wait_bit(3, 40, n);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (wdt_rst_o) seen = 1;
    end
    chk("R7 no pulse without arm", seen, 0);
    chk("R7 no reset flag", int'(ctl_rdata[2]), 0);
  endtask

  task automatic t_clear_cancel();
    int n, fl = -1, rr = -1;
    do_reset();
    wr(cw(1, 0, 0, 1, 0, 2) | M_CLR);
    wait_bit(3, 40, n);
    repeat (5) @(negedge clk);
    wr(cw(1, 0, 0, 1, 0, 2) | M_CLR | M_INTF);
    chk("R8 clear bit reads 1", int'(ctl_rdata[0]), 1);
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == 1) chk("R8 clear bit self-clears", int'(ctl_rdata[0]), 0);
      if (ctl_rdata[3] && fl < 0) fl = i;
      if (wdt_rst_o && rr < 0) rr = i;
    end
    chk("R8 restart interval", fl, 16);
    chk("R8 old reset cancelled", rr, 34);
  endtask

  task automatic t_disable();
    int n, seen = 0;
    do_reset();
    wr(cw(1, 0, 0, 1, 0, 2) | M_CLR);
    wait_bit(3, 40, n);
    repeat (5) @(negedge clk);
    wr(cw(0, 0, 0, 1, 0, 2) | M_INTF);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wdt_rst_o) seen = 1;
    end
    chk("R9 pending reset dropped", seen, 0);
    wr(cw(1, 0, 0, 1, 0, 2));
    wait_bit(3, 40, n);
    chk("R9 count restarted", n, 16);
  endtask

  task automatic t_force();
    int n;
    do_reset();
    force_en = 1;
    #0.1;
    chk("R10 run reads 1", int'(ctl_rdata[7]), 1);
    wait_bit(3, 40, n);
    chk("R10 forced interval", n, 16);
  endtask

  initial begin
    t_reset();
    for (int k = 0; k < 3; k++) t_interval(k);
    t_wake();
    t_delay(0, 1026);
    t_delay(1, 130);
    t_delay(2, 18);
    t_delay(3, 3);
    t_no_arm();
    t_clear_cancel();
    t_disable();
    t_force();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule